// File: doc/BRIEF.md
# Transceiver Attribute Write Sequencer

This block applies one analog attribute change to a serial transceiver through its indirect attribute port. A caller gives a 16-bit attribute code and a 16-bit attribute value and pulses a start input. The block then masters a byte-wide register bus. It stages the two value bytes and the two code bytes, launches the operation, and checks that the completion flag is set. It then polls the transceiver's busy bit until it drops, and finally writes the completion flag to clear it.

Each bus access is held until the responder acknowledges it, so a slow or stalled register bus only stretches the sequence. Two sticky error outputs report a missing completion flag and a busy bit that never drops within the retry budget. A typical use is to switch a lane's internal serial loopback on (code 0x0008, value 0x0001) or off (value 0x0000) before the link is reset.

Top module: `xcvr_attr_seq`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o, done_o, bus_req_o, err_flag_o and err_timeout_o are 0 until a start is accepted.
- R2: start_i is accepted only when busy_o and done_o are both 0. An accepted start latches code_i and value_i and raises busy_o on the next cycle. A start_i while busy_o is 1 is ignored, and the latched code and value do not change.
- R3: The first five bus accesses are writes in this fixed order: address 0x84 with value[7:0], 0x85 with value[15:8], 0x86 with code[7:0], 0x87 with code[15:8], then 0x90 with data 0x01.
- R4: An access is complete only in a cycle where bus_req_o and bus_ack_i are both 1. Until then bus_req_o stays 1 and bus_addr_o, bus_we_o and bus_wdata_o hold steady, for a stall of any length.
- R5: After the launch write, one read of address 0x8A is made. If bit 7 of the returned byte is 0, err_flag_o is set and the busy poll is skipped.
- R6: If the flag is set, address 0x8B is read repeatedly until bit 0 of the returned byte is 0, with at most POLL_MAX reads. If all POLL_MAX reads return bit 0 as 1, err_timeout_o is set.
- R7: Every sequence ends with a write of data 0x80 to address 0x8A, error or not. In the cycle after that write completes, done_o is 1 for exactly one cycle with busy_o 0.
- R8: err_flag_o and err_timeout_o hold their value after done_o and are cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one attribute change |
| code_i | input | 16 | Attribute code |
| value_i | input | 16 | Attribute value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_flag_o | output | 1 | Completion flag was not set after the launch |
| err_timeout_o | output | 1 | Busy bit still set after POLL_MAX reads |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access complete |

## Verification
A state register that skips or repeats a step shows at the bus within one access: the logged address/data pair out of order, or a seventh write. A poll counter off by one shows as one read of 0x8B too many or too few on the run that clears on the last allowed read, and on the run that times out. A wrong branch after the flag read shows as a stray 0x8B read or a missing error bit at the done pulse. Stalled acknowledges check that nothing advances without a completed access.

// File: rtl/attr_seq_pkg.sv
package attr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VAL_LO,
    ST_VAL_HI,
    ST_CODE_LO,
    ST_CODE_HI,
    ST_LAUNCH,
    ST_FLAG_RD,
    ST_POLL_RD,
    ST_FLAG_CLR,
    ST_DONE
  } seq_state_e;

  localparam logic [7:0] A_VAL_LO  = 8'h84;
  localparam logic [7:0] A_VAL_HI  = 8'h85;
  localparam logic [7:0] A_CODE_LO = 8'h86;
  localparam logic [7:0] A_CODE_HI = 8'h87;
  localparam logic [7:0] A_LAUNCH  = 8'h90;
  localparam logic [7:0] A_FLAG    = 8'h8A;
  localparam logic [7:0] A_BUSY    = 8'h8B;

  localparam logic [7:0] D_LAUNCH  = 8'h01;
  localparam logic [7:0] D_FLAG_CLR = 8'h80;

  localparam int FLAG_BIT = 7;
  localparam int BUSY_BIT = 0;
endpackage

// File: rtl/attr_step_map.sv
module attr_step_map
  import attr_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  seq_state_e        state_i,
  input  logic [15:0]       code_i,
  input  logic [15:0]       value_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o
);
  logic [7:0] addr_b;

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b1;
    addr_b  = 8'h00;
    wdata_o = 8'h00;
    unique case (state_i)
      ST_VAL_LO:   begin addr_b = A_VAL_LO;  wdata_o = value_i[7:0];  end
      ST_VAL_HI:   begin addr_b = A_VAL_HI;  wdata_o = value_i[15:8]; end
      ST_CODE_LO:  begin addr_b = A_CODE_LO; wdata_o = code_i[7:0];   end
      ST_CODE_HI:  begin addr_b = A_CODE_HI; wdata_o = code_i[15:8];  end
      ST_LAUNCH:   begin addr_b = A_LAUNCH;  wdata_o = D_LAUNCH;      end
      ST_FLAG_RD:  begin addr_b = A_FLAG;    we_o = 1'b0;             end
      ST_POLL_RD:  begin addr_b = A_BUSY;    we_o = 1'b0;             end
      ST_FLAG_CLR: begin addr_b = A_FLAG;    wdata_o = D_FLAG_CLR;    end
      default:     begin req_o = 1'b0;       we_o = 1'b0;             end
    endcase
  end

  generate
    if (ADDR_W > 8) begin : g_wide
      assign addr_o = {{(ADDR_W-8){1'b0}}, addr_b};
    end else begin : g_narrow
      assign addr_o = addr_b[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/attr_poll_ctr.sv
module attr_poll_ctr #(
  parameter int POLL_MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_MAX - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_LAST);

  // count never passes the last allowed read
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/xcvr_attr_seq.sv
module xcvr_attr_seq
  import attr_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int POLL_MAX = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       code_i,
  input  logic [15:0]       value_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_flag_o,
  output logic              err_timeout_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_ack_i
);
  seq_state_e  state_q, state_d;
  logic [15:0] code_q, value_q;
  logic        err_flag_q, err_to_q;
  logic        acc, accept, poll_last, poll_inc;

  assign acc    = bus_req_o && bus_ack_i;
  assign accept = (state_q == ST_IDLE) && start_i;
  assign poll_inc = (state_q == ST_POLL_RD) && acc && bus_rdata_i[BUSY_BIT] && !poll_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_VAL_LO;
      ST_VAL_LO:  if (acc) state_d = ST_VAL_HI;
      ST_VAL_HI:  if (acc) state_d = ST_CODE_LO;
      ST_CODE_LO: if (acc) state_d = ST_CODE_HI;
      ST_CODE_HI: if (acc) state_d = ST_LAUNCH;
      ST_LAUNCH:  if (acc) state_d = ST_FLAG_RD;
      ST_FLAG_RD: if (acc) state_d = bus_rdata_i[FLAG_BIT] ? ST_POLL_RD : ST_FLAG_CLR;
      ST_POLL_RD: if (acc && (!bus_rdata_i[BUSY_BIT] || poll_last)) state_d = ST_FLAG_CLR;
      ST_FLAG_CLR: if (acc) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      code_q     <= '0;
      value_q    <= '0;
      err_flag_q <= 1'b0;
      err_to_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        code_q     <= code_i;
        value_q    <= value_i;
        err_flag_q <= 1'b0;
        err_to_q   <= 1'b0;
      end
      if (state_q == ST_FLAG_RD && acc && !bus_rdata_i[FLAG_BIT]) err_flag_q <= 1'b1;
      if (state_q == ST_POLL_RD && acc && bus_rdata_i[BUSY_BIT] && poll_last) err_to_q <= 1'b1;
    end
  end

  attr_step_map #(.ADDR_W(ADDR_W)) u_map (
    .state_i (state_q),
    .code_i  (code_q),
    .value_i (value_q),
    .req_o   (bus_req_o),
    .we_o    (bus_we_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  attr_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .inc_i   (poll_inc),
    .last_o  (poll_last)
  );

  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o        = (state_q == ST_DONE);
  assign err_flag_o    = err_flag_q;
  assign err_timeout_o = err_to_q;

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> busy_o);

  p_hold_args_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(code_q) && $stable(value_q)));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !bus_req_o));

  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> (!err_flag_o && !err_timeout_o));

  p_err_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_flag_o && err_timeout_o));
endmodule

// File: tb/xcvr_attr_seq_tb_top.sv
module xcvr_attr_seq_tb_top;
  localparam int POLL_MAX = 8;
  localparam int NVEC = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] code_i = '0, value_i = '0;
  logic busy_o, done_o, err_flag_o, err_timeout_o;
  logic bus_req_o, bus_we_o, bus_ack_i;
  logic [7:0] bus_addr_o, bus_wdata_o, bus_rdata_i;

  always #5 clk = ~clk;

  xcvr_attr_seq #(.ADDR_W(8), .POLL_MAX(POLL_MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .code_i(code_i), .value_i(value_i),
    .busy_o(busy_o), .done_o(done_o), .err_flag_o(err_flag_o), .err_timeout_o(err_timeout_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
  );

  // responder model settings, driven only by the initial block
  int   rsp_delay = 0;
  logic rsp_flag  = 1'b1;
  int   rsp_busy  = 0;
  logic clr_log   = 1'b0;

  // responder state
  int         wcnt;
  logic       flag_bit;
  int         busy_left;
  int         rd_cnt;
  int         log_n;
  logic [7:0] log_addr [16];
  logic [7:0] log_data [16];

  assign bus_ack_i   = bus_req_o && (wcnt == rsp_delay);
  assign bus_rdata_i = (bus_addr_o == 8'h8A) ? {flag_bit, 7'b0} :
                       (bus_addr_o == 8'h8B) ? {7'b0, busy_left != 0} : 8'h00;

  always @(posedge clk) begin
    if (clr_log) begin
      wcnt <= 0; flag_bit <= 1'b0; busy_left <= 0; rd_cnt <= 0; log_n <= 0;
    end else if (bus_req_o && bus_ack_i) begin
      wcnt <= 0;
      if (bus_we_o) begin
        if (log_n < 16) begin
          log_addr[log_n] <= bus_addr_o;
          log_data[log_n] <= bus_wdata_o;
        end
        log_n <= log_n + 1;
        if (bus_addr_o == 8'h90 && bus_wdata_o[0]) begin
          flag_bit <= rsp_flag; busy_left <= rsp_busy;
        end
        if (bus_addr_o == 8'h8A && bus_wdata_o[7]) flag_bit <= 1'b0;
      end else if (bus_addr_o == 8'h8B) begin
        rd_cnt <= rd_cnt + 1;
        if (busy_left != 0) busy_left <= busy_left - 1;
      end
    end else if (bus_req_o) begin
      wcnt <= wcnt + 1;
    end
  end

  // code, value, delay, flag, busy reads, exp err_flag, exp err_timeout, exp 0x8B reads
  typedef struct packed {
    logic [15:0] code; logic [15:0] value; logic [3:0] dly; logic flag;
    logic [4:0] busy; logic e_flag; logic e_to; logic [4:0] reads;
  } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0008, 16'h0001, 4'd0, 1'b1, 5'd0, 1'b0, 1'b0, 5'd1},
    '{16'h0008, 16'h0000, 4'd3, 1'b1, 5'd2, 1'b0, 1'b0, 5'd3},
    '{16'hA55A, 16'h3CC3, 4'd1, 1'b0, 5'd3, 1'b1, 1'b0, 5'd0},
    '{16'h1234, 16'hFEDC, 4'd0, 1'b1, 5'd7, 1'b0, 1'b0, 5'd8},
    '{16'h00FF, 16'hFF00, 4'd2, 1'b1, 5'd8, 1'b0, 1'b1, 5'd8},
    '{16'h0008, 16'h0001, 4'd0, 1'b1, 5'd1, 1'b0, 1'b0, 5'd2}
  };

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  // pulses start, waits for done_o at a negedge; returns 1 if done seen
  task automatic run_op(input logic [15:0] c, input logic [15:0] v, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    code_i = c; value_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", {31'b0, busy_o}, 1);
    for (int i = 0; i < 2000; i++) begin
      if (done_o === 1'b1) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_writes(input logic [15:0] c, input logic [15:0] v);
    logic [7:0] ea [6];
    logic [7:0] ed [6];
    ea = '{8'h84, 8'h85, 8'h86, 8'h87, 8'h90, 8'h8A};
    ed = '{v[7:0], v[15:8], c[7:0], c[15:8], 8'h01, 8'h80};
    chk(log_n == 6, "R3/R7 write count", log_n, 6);
    for (int k = 0; k < 5; k++)
      chk(log_addr[k] == ea[k] && log_data[k] == ed[k], "R3 staging write",
          {log_addr[k], log_data[k]}, {ea[k], ed[k]});
    chk(log_addr[5] == ea[5] && log_data[5] == ed[5], "R7 flag clear write",
        {log_addr[5], log_data[5]}, {ea[5], ed[5]});
  endtask

  initial begin
    bit seen;
    clr_log = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle under reset
    chk({busy_o, done_o, bus_req_o, err_flag_o, err_timeout_o} == 5'b0, "R1 in reset",
        {busy_o, done_o, bus_req_o, err_flag_o, err_timeout_o}, 0);
    rst_ni = 1'b1;
    clr_log = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, bus_req_o, err_flag_o, err_timeout_o} == 5'b0, "R1 after reset",
        {busy_o, done_o, bus_req_o, err_flag_o, err_timeout_o}, 0);

    for (int n = 0; n < NVEC; n++) begin
      rsp_delay = int'(VECS[n].dly); rsp_flag = VECS[n].flag; rsp_busy = int'(VECS[n].busy);
      reset_log();
      run_op(VECS[n].code, VECS[n].value, seen);
      chk(seen, "R7 done seen", {31'b0, seen}, 1);
      chk(err_flag_o === VECS[n].e_flag, "R5 err_flag_o", {31'b0, err_flag_o}, {31'b0, VECS[n].e_flag});
      chk(err_timeout_o === VECS[n].e_to, "R6 err_timeout_o", {31'b0, err_timeout_o}, {31'b0, VECS[n].e_to});
      chk(rd_cnt == int'(VECS[n].reads), "R6 busy poll reads", rd_cnt, {27'b0, VECS[n].reads});
      check_writes(VECS[n].code, VECS[n].value);
      @(negedge clk);
      chk(done_o === 1'b0 && busy_o === 1'b0, "R7 done single pulse", {30'b0, done_o, busy_o}, 0);
      chk(err_flag_o === VECS[n].e_flag && err_timeout_o === VECS[n].e_to, "R8 errors held",
          {30'b0, err_flag_o, err_timeout_o}, {30'b0, VECS[n].e_flag, VECS[n].e_to});
    end

    // R2: start and new arguments while busy are ignored (R4 under stall)
    rsp_delay = 3; rsp_flag = 1'b1; rsp_busy = 2;
    reset_log();
    @(negedge clk);
    code_i = 16'h0BAD; value_i = 16'hC0DE; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    code_i = 16'h7777; value_i = 16'h5555; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done_o === 1'b1) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R2 done with start while busy", {31'b0, seen}, 1);
    check_writes(16'h0BAD, 16'hC0DE);
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && log_n == 6, "R2 no second sequence", {busy_o, 31'(log_n)}, 6);

    // R1: reset in mid-sequence returns the block to idle
    rsp_delay = 2; rsp_busy = 5;
    reset_log();
    @(negedge clk);
    code_i = 16'h0008; value_i = 16'h0001; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk({busy_o, done_o, bus_req_o} == 3'b0, "R1 mid-sequence reset", {busy_o, done_o, bus_req_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    rsp_delay = 0; rsp_busy = 0;
    reset_log();
    run_op(16'h0008, 16'h0000, seen);
    chk(seen && !err_flag_o && !err_timeout_o, "R1 run after reset",
        {seen, err_flag_o, err_timeout_o}, 3'b100);
    check_writes(16'h0008, 16'h0000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule